// File: doc/BRIEF.md
# Deferred-Start Frame Transmit Controller

This block decides when a framed serial transmitter may pull bytes out of its transmit FIFO, and what happens when that FIFO runs dry in the middle of a frame. The host loads bytes into the FIFO, programs a frame length, and picks one of two start policies. In immediate mode a frame opens as soon as the FIFO holds data. In deferred mode bytes pile up until the host pulses a start strobe. Each frame hands exactly the programmed number of bytes to the framer, and then the block raises a one-cycle end-of-frame command.

If the FIFO empties before the frame is complete, the block can respond in one of two ways. With underrun handling on, it closes the frame at once, marks its CRC as deliberately bad, and locks the transmitter. The lock clears only after the host resets the FIFO and, in a later cycle, performs a resume read. With underrun handling off, it leaves the frame open and asks the framer to stretch the stop bit until more data arrives.

Bit encoding, CRC generation, flag insertion and the FIFO storage itself are outside this block. The FIFO reports only its empty status, and a byte counts as moved in any cycle where `byte_req` and `framer_rdy` are both high.

Top module: `frame_tx_gate`

## Requirements
- R1: After reset, `byte_req`, `frame_end`, `crc_bad`, `stop_extend` and `tx_blocked` are all low.
- R2: With `cfg_defer_en` low and the transmitter unlocked, a frame opens whenever `fifo_empty` is low. While the frame is open, `byte_req` is high whenever the FIFO is non-empty, and one byte is consumed in each cycle where `byte_req` and `framer_rdy` are both high.
- R3: Once `cfg_frame_len` bytes have been consumed, `frame_end` pulses for exactly one cycle with `crc_bad` low. Any bytes still in the FIFO then form the next frame. A FIFO that empties exactly on the last byte is not an underrun.
- R4: With `cfg_defer_en` high, no byte is requested until a `start_stb` pulse has been seen in an idle cycle. A start that arrives while the FIFO is empty is remembered. Each accepted start opens exactly one frame.
- R5: A `start_stb` pulse that arrives while a frame is open is discarded and does not launch a later frame.
- R6: With `cfg_urun_off` low, if the FIFO is empty while a frame is open and short of its length, the frame is aborted with a one-cycle `frame_end` and `crc_bad` high in that same cycle.
- R7: An underrun sets `tx_blocked`. While `tx_blocked` is high, no frame opens and `byte_req` stays low, even if the FIFO holds data.
- R8: `tx_blocked` clears after a `fifo_rst_stb` pulse followed, in a later cycle, by a `resume_rd_stb` pulse. Normal transmission then resumes.
- R9: A `resume_rd_stb` pulse that is not preceded by a `fifo_rst_stb` pulse after the underrun leaves `tx_blocked` set.
- R10: With `cfg_urun_off` high, an empty FIFO inside an open frame raises `stop_extend` and produces neither `frame_end` nor `tx_blocked`. The frame continues with the next bytes that arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_defer_en | input | 1 | 1 = wait for a host start pulse before each frame |
| cfg_urun_off | input | 1 | 1 = stretch the stop bit on an empty FIFO instead of aborting |
| cfg_frame_len | input | LEN_W | Bytes per frame (0 means 2^LEN_W) |
| start_stb | input | 1 | Host start command, one-cycle pulse |
| fifo_rst_stb | input | 1 | Host FIFO reset, one-cycle pulse |
| resume_rd_stb | input | 1 | Host read of the resume register, one-cycle pulse |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| framer_rdy | input | 1 | Framer can accept a byte this cycle |
| byte_req | output | 1 | Request or pop one byte from the FIFO to the framer |
| frame_end | output | 1 | Close the current frame (one-cycle pulse) |
| crc_bad | output | 1 | Append a corrupted CRC to the frame being closed |
| stop_extend | output | 1 | Stretch the stop bit while the FIFO is empty |
| tx_blocked | output | 1 | Transmitter locked after an underrun |

## Verification
A wrong remaining-byte count shows up at the ports within one frame, as an end-of-frame pulse that comes too early or too late relative to the bytes consumed. The sweep catches it by comparing consumed bytes and pulse counts against quotient and remainder arithmetic for every small length and load. A lost or stale start flag shows up immediately as bytes requested in deferred mode without a start, or as a frame that never opens. A lock flag that clears too easily, or too late, shows up in the first cycle after the recovery strobes, through `tx_blocked` and whether data queued behind the lock drains.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ftg_state_e;
endpackage

// File: rtl/ftg_seq.sv
module ftg_seq
    import ftg_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_defer_en,
    input  logic             cfg_urun_off,
    input  logic [LEN_W-1:0] cfg_frame_len,
    input  logic             start_stb,
    input  logic             fifo_empty,
    input  logic             framer_rdy,
    input  logic             locked,
    output logic             byte_req,
    output logic             frame_end,
    output logic             crc_bad,
    output logic             stop_extend,
    output logic             urun_evt
);
    typedef struct packed {
        ftg_state_e       state;
        logic [LEN_W-1:0] remain;
        logic             armed;
        logic             eof;
        logic             bad;
    } seq_t;

    seq_t q, d;
    logic pop;
    logic go;

    always_comb begin
        d        = q;
        d.eof    = 1'b0;
        d.bad    = 1'b0;
        byte_req = (q.state == ST_SEND) && !fifo_empty;
        pop      = byte_req && framer_rdy;
        urun_evt = (q.state == ST_SEND) && fifo_empty && !cfg_urun_off;
        stop_extend = (q.state == ST_SEND) && fifo_empty && cfg_urun_off;
        go       = (q.state == ST_IDLE) && !locked && !fifo_empty
                   && (!cfg_defer_en || q.armed);

        if (start_stb && cfg_defer_en && (q.state == ST_IDLE)) begin
            d.armed = 1'b1;
        end

        unique case (q.state)
            ST_IDLE: begin
                if (go) begin
                    d.state  = ST_SEND;
                    d.remain = cfg_frame_len;
                    d.armed  = 1'b0;
                end
            end
            ST_SEND: begin
                if (pop) begin
                    if (q.remain == LEN_W'(1)) begin
                        d.eof   = 1'b1;
                        d.state = ST_IDLE;
                    end
                    d.remain = q.remain - LEN_W'(1);
                end else if (urun_evt) begin
                    d.eof   = 1'b1;
                    d.bad   = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, remain: '0, armed: 1'b0, eof: 1'b0, bad: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign frame_end = q.eof;
    assign crc_bad   = q.bad;

    assert_eof_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    assert_bad_with_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_bad |-> frame_end);

    assert_defer_needs_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_SEND) && ($past(q.state) == ST_IDLE) && $past(cfg_defer_en))
        |-> $past(q.armed));

    assert_extend_no_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_extend |=> !crc_bad);
endmodule

// File: rtl/ftg_lock.sv
module ftg_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic urun_evt,
    input  logic fifo_rst_stb,
    input  logic resume_rd_stb,
    output logic locked
);
    typedef struct packed {
        logic locked;
        logic flushed;
    } lock_t;

    lock_t q, d;

    always_comb begin
        d = q;
        if (urun_evt) begin
            d.locked  = 1'b1;
            d.flushed = 1'b0;
        end else if (q.locked) begin
            if (fifo_rst_stb) begin
                d.flushed = 1'b1;
            end
            if (resume_rd_stb && q.flushed) begin
                d.locked  = 1'b0;
                d.flushed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{locked: 1'b0, flushed: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign locked = q.locked;

    assert_lock_from_urun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(urun_evt));

    assert_clear_needs_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(resume_rd_stb && q.flushed));
endmodule

// File: rtl/frame_tx_gate.sv
module frame_tx_gate #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_defer_en,
    input  logic             cfg_urun_off,
    input  logic [LEN_W-1:0] cfg_frame_len,
    input  logic             start_stb,
    input  logic             fifo_rst_stb,
    input  logic             resume_rd_stb,
    input  logic             fifo_empty,
    input  logic             framer_rdy,
    output logic             byte_req,
    output logic             frame_end,
    output logic             crc_bad,
    output logic             stop_extend,
    output logic             tx_blocked
);
    logic urun_evt;
    logic locked;

    ftg_seq #(.LEN_W(LEN_W)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_defer_en (cfg_defer_en),
        .cfg_urun_off (cfg_urun_off),
        .cfg_frame_len(cfg_frame_len),
        .start_stb    (start_stb),
        .fifo_empty   (fifo_empty),
        .framer_rdy   (framer_rdy),
        .locked       (locked),
        .byte_req     (byte_req),
        .frame_end    (frame_end),
        .crc_bad      (crc_bad),
        .stop_extend  (stop_extend),
        .urun_evt     (urun_evt)
    );

    ftg_lock lock_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .urun_evt     (urun_evt),
        .fifo_rst_stb (fifo_rst_stb),
        .resume_rd_stb(resume_rd_stb),
        .locked       (locked)
    );

    assign tx_blocked = locked;

    assert_no_req_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_blocked |-> !byte_req);
endmodule

// File: tb/frame_tx_gate_tb_top.sv
module frame_tx_gate_tb_top;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_defer_en = 1'b0;
    logic             cfg_urun_off = 1'b0;
    logic [LEN_W-1:0] cfg_frame_len = '0;
    logic             start_stb = 1'b0;
    logic             fifo_rst_stb = 1'b0;
    logic             resume_rd_stb = 1'b0;
    logic             fifo_empty;
    logic             framer_rdy = 1'b1;
    logic             byte_req, frame_end, crc_bad, stop_extend, tx_blocked;

    int loaded = 0;
    int popped = 0;
    int eof_n  = 0;
    int bad_n  = 0;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    assign fifo_empty = (loaded == popped);

    frame_tx_gate #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_defer_en(cfg_defer_en),
        .cfg_urun_off(cfg_urun_off), .cfg_frame_len(cfg_frame_len),
        .start_stb(start_stb), .fifo_rst_stb(fifo_rst_stb),
        .resume_rd_stb(resume_rd_stb), .fifo_empty(fifo_empty),
        .framer_rdy(framer_rdy), .byte_req(byte_req), .frame_end(frame_end),
        .crc_bad(crc_bad), .stop_extend(stop_extend), .tx_blocked(tx_blocked)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            popped <= 0;
            eof_n  <= 0;
            bad_n  <= 0;
        end else begin
            if (byte_req && framer_rdy) popped <= popped + 1;
            if (frame_end) eof_n <= eof_n + 1;
            if (crc_bad)   bad_n <= bad_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        cyc(1);
        s = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        loaded = 0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    initial begin
        cyc(150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 byte_req", int'(byte_req), 0);
        chk("R1 frame_end", int'(frame_end), 0);
        chk("R1 crc_bad", int'(crc_bad), 0);
        chk("R1 stop_extend", int'(stop_extend), 0);
        chk("R1 tx_blocked", int'(tx_blocked), 0);

        // Sweep: frame length, load size, underrun policy
        for (int off = 0; off < 2; off++) begin
            for (int len = 1; len <= 4; len++) begin
                for (int n = 1; n <= 7; n++) begin
                    int fq, fr;
                    bit urun;
                    fq = n / len;
                    fr = n % len;
                    urun = (fr > 0) && (off == 0);
                    cfg_defer_en  = 1'b0;
                    cfg_urun_off  = off[0];
                    cfg_frame_len = LEN_W'(len);
                    framer_rdy    = 1'b1;
                    do_reset();
                    loaded = n;
                    cyc(3 * n + 8);
                    chk("R2 bytes consumed", popped, n);
                    chk("R3/R6 end count", eof_n, fq + int'(urun));
                    chk("R6 bad crc count", bad_n, int'(urun));
                    chk("R7 blocked after run", int'(tx_blocked), int'(urun));
                    chk("R10 stop extend", int'(stop_extend), int'((fr > 0) && (off == 1)));
                    if (urun) begin
                        pulse(resume_rd_stb);
                        cyc(2);
                        chk("R9 resume alone keeps block", int'(tx_blocked), 1);
                        loaded = loaded + 2;
                        cyc(8);
                        chk("R7 no bytes while blocked", popped, n);
                        chk("R7 no request while blocked", int'(byte_req), 0);
                        loaded = popped;
                        pulse(fifo_rst_stb);
                        pulse(resume_rd_stb);
                        cyc(2);
                        chk("R8 block cleared", int'(tx_blocked), 0);
                        loaded = loaded + len;
                        cyc(3 * len + 8);
                        chk("R8 transmit resumes", popped, n + len);
                        chk("R3 good frame after recovery", eof_n, fq + 2);
                        chk("R3 no extra bad crc", bad_n, 1);
                    end else if (fr > 0) begin
                        loaded = loaded + (len - fr);
                        cyc(3 * len + 8);
                        chk("R10 frame completes", eof_n, fq + 1);
                        chk("R10 no bad crc", bad_n, 0);
                        chk("R10 extend dropped", int'(stop_extend), 0);
                        chk("R10 not blocked", int'(tx_blocked), 0);
                    end
                end
            end
        end

        // R2: framer not ready holds bytes
        cfg_defer_en = 1'b0; cfg_urun_off = 1'b0; cfg_frame_len = 8'd3;
        do_reset();
        framer_rdy = 1'b0;
        loaded = 3;
        cyc(6);
        chk("R2 no pop without ready", popped, 0);
        chk("R2 request held", int'(byte_req), 1);
        framer_rdy = 1'b1;
        cyc(8);
        chk("R2 pops after ready", popped, 3);
        chk("R3 one frame", eof_n, 1);

        // R4: deferred start
        cfg_defer_en = 1'b1; cfg_frame_len = 8'd2;
        do_reset();
        loaded = 4;
        cyc(10);
        chk("R4 held without start", popped, 0);
        chk("R4 no request", int'(byte_req), 0);
        pulse(start_stb);
        cyc(10);
        chk("R4 one frame sent", popped, 2);
        chk("R4 one end", eof_n, 1);
        cyc(10);
        chk("R4 no second frame", popped, 2);
        pulse(start_stb);
        cyc(10);
        chk("R4 second start", popped, 4);
        chk("R4 second end", eof_n, 2);
        chk("R4 good crc", bad_n, 0);

        // R4: start remembered while FIFO empty
        do_reset();
        pulse(start_stb);
        cyc(4);
        loaded = 2;
        cyc(10);
        chk("R4 early start kept", popped, 2);

        // R5: start during open frame ignored
        cfg_frame_len = 8'd3;
        do_reset();
        framer_rdy = 1'b0;
        loaded = 3;
        pulse(start_stb);
        cyc(3);
        pulse(start_stb);
        framer_rdy = 1'b1;
        cyc(10);
        chk("R5 first frame", popped, 3);
        loaded = loaded + 3;
        cyc(10);
        chk("R5 stray start dropped", popped, 3);
        pulse(start_stb);
        cyc(10);
        chk("R5 new start works", popped, 6);
        chk("R5 end count", eof_n, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule